// File: doc/BRIEF.md
# Two-Key Register Write-Protection Gate

This block sits beside a peripheral's register file and watches every bus access. It holds two 32-bit key registers. Protected registers accept writes only while both keys hold their fixed magic words. For any write the bus makes to an address other than a key, it produces a qualified write enable that the surrounding register file uses in place of the raw write strobe. It also holds a small bank of 32-bit scratch words, guarded by the same gate.

Software opens the gate by storing the two magic words into the two keys and closes it by storing any other value, usually zero. Key writes are never blocked. Reads are never blocked. Read data for the keys and the scratch words is returned combinationally from the current contents. Any other address reads as zero from this block.

Top module: `wp_unlock_gate`

## Requirements
- R1: During and after reset `unlocked` is low, and both keys (0x6C, 0x70) and all scratch words (0x60, 0x64, 0x68) read zero.
- R2: `unlocked` goes high on the clock edge after the key at 0x6C holds 0x83E70B13 and the key at 0x70 holds 0x95A4F1E0 together. The two key writes may come in either order.
- R3: A write of any value other than its magic word (zero included) to either key drives `unlocked` low from the next edge.
- R4: While locked, `protWrEn` stays low and writes to scratch words leave their contents unchanged.
- R5: While unlocked, a write to any non-key address raises `protWrEn` in the same cycle. A write to a scratch word stores the data.
- R6: Key writes are always accepted, and a key reads back the value last written to it.
- R7: Scratch words can be read while locked. `busRData` shows the contents held before any write in the same cycle.
- R8: `protWrEn` is never raised by a read or by a write to a key address.
- R9: Addresses other than the keys and the scratch words return zero on `busRData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the current access |
| busWr | input | 1 | Write strobe of the current access (low means read) |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for keys and scratch words, zero elsewhere |
| protWrEn | output | 1 | Qualified write enable for protected registers |
| unlocked | output | 1 | High while both keys hold their magic words |

## Verification
A key write and an access to a protected address cannot share one bus cycle. The real overlap is between a key write that breaks the lock and the protected write in the very next cycle. Another overlap is a write and a read-back of the same word in one cycle. The bench places a relocking key write directly before a scratch write, then reads the scratch word to confirm the data was dropped. It also compares the read data sampled during a write cycle against the old contents.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;
  localparam int SCR_NUM = 3;

  typedef struct packed {
    logic               wrKey0;
    logic               wrKey1;
    logic [SCR_NUM-1:0] wrScr;
    logic               selKey0;
    logic               selKey1;
    logic [SCR_NUM-1:0] selScr;
  } wpStrobes_t;
endpackage

// File: rtl/wp_unlock_ctrl.sv
module wp_unlock_ctrl
  import wp_unlock_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] KEY0_OFFS = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_OFFS = 8'h70,
  parameter logic [ADDR_W-1:0] SCR_BASE  = 8'h60
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              unlocked,
  output wpStrobes_t        strobes,
  output logic              protWrEn
);
  logic isKey;

  assign strobes.selKey0 = (busAddr == KEY0_OFFS);
  assign strobes.selKey1 = (busAddr == KEY1_OFFS);
  assign strobes.wrKey0  = busWr & strobes.selKey0;
  assign strobes.wrKey1  = busWr & strobes.selKey1;
  assign isKey           = strobes.selKey0 | strobes.selKey1;

  for (genvar i = 0; i < SCR_NUM; i++) begin : g_scr
    localparam logic [ADDR_W-1:0] SCR_OFFS = ADDR_W'(SCR_BASE + 4 * i);
    assign strobes.selScr[i] = (busAddr == SCR_OFFS);
    assign strobes.wrScr[i]  = busWr & unlocked & strobes.selScr[i];
  end

  assign protWrEn = busWr & unlocked & ~isKey;
endmodule

// File: rtl/wp_unlock_datapath.sv
module wp_unlock_datapath
  import wp_unlock_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] KEY0_MAGIC = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_MAGIC = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobes_t        strobes,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              unlocked
);
  logic [DATA_W-1:0] key0Q, key1Q;
  logic [DATA_W-1:0] scrQ [SCR_NUM];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      key0Q <= '0;
      key1Q <= '0;
    end else begin
      if (strobes.wrKey0) key0Q <= busWData;
      if (strobes.wrKey1) key1Q <= busWData;
    end
  end

  for (genvar i = 0; i < SCR_NUM; i++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rstN)                 scrQ[i] <= '0;
      else if (strobes.wrScr[i]) scrQ[i] <= busWData;
    end
  end

  assign unlocked = (key0Q == KEY0_MAGIC) && (key1Q == KEY1_MAGIC);

  always_comb begin
    busRData = '0;
    if (strobes.selKey0) busRData = key0Q;
    if (strobes.selKey1) busRData = key1Q;
    for (int i = 0; i < SCR_NUM; i++)
      if (strobes.selScr[i]) busRData = scrQ[i];
  end
endmodule

// File: rtl/wp_unlock_gate.sv
module wp_unlock_gate
  import wp_unlock_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] KEY0_OFFS  = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_OFFS  = 8'h70,
  parameter logic [ADDR_W-1:0] SCR_BASE   = 8'h60,
  parameter logic [DATA_W-1:0] KEY0_MAGIC = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_MAGIC = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              protWrEn,
  output logic              unlocked
);
  wpStrobes_t strobes;

  wp_unlock_ctrl #(
    .ADDR_W(ADDR_W), .KEY0_OFFS(KEY0_OFFS), .KEY1_OFFS(KEY1_OFFS), .SCR_BASE(SCR_BASE)
  ) ctrl_i (
    .busAddr(busAddr), .busWr(busWr), .unlocked(unlocked),
    .strobes(strobes), .protWrEn(protWrEn)
  );

  wp_unlock_datapath #(
    .DATA_W(DATA_W), .KEY0_MAGIC(KEY0_MAGIC), .KEY1_MAGIC(KEY1_MAGIC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWData(busWData),
    .busRData(busRData), .unlocked(unlocked)
  );
endmodule

// File: rtl/wp_unlock_gate_chk.sv
module wp_unlock_gate_chk #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] KEY0_OFFS  = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_OFFS  = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_MAGIC = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_MAGIC = 32'h95A4_F1E0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [DATA_W-1:0] busWData,
  input logic [DATA_W-1:0] busRData,
  input logic              protWrEn,
  input logic              unlocked
);
  logic keyAddr;
  assign keyAddr = (busAddr == KEY0_OFFS) || (busAddr == KEY1_OFFS);

  a_r2_rise_follows_key_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(busWr && keyAddr));

  a_r3_bad_key0_locks: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == KEY0_OFFS && busWData != KEY0_MAGIC) |=> !unlocked);

  a_r3_bad_key1_locks: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == KEY1_OFFS && busWData != KEY1_MAGIC) |=> !unlocked);

  a_r4_locked_no_enable: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !protWrEn);

  a_r5_unlocked_passes: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && busWr && !keyAddr) |-> protWrEn);

  a_r8_enable_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    protWrEn |-> (busWr && !keyAddr));

  a_r1_reset_locked: assert property (@(posedge clk)
    !rstN |=> !unlocked);
endmodule

bind wp_unlock_gate wp_unlock_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY0_OFFS(KEY0_OFFS), .KEY1_OFFS(KEY1_OFFS),
  .KEY0_MAGIC(KEY0_MAGIC), .KEY1_MAGIC(KEY1_MAGIC)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWData(busWData),
  .busRData(busRData), .protWrEn(protWrEn), .unlocked(unlocked)
);

// File: tb/wp_unlock_gate_tb.sv
module wp_unlock_gate_tb_top;
  localparam logic [31:0] M0 = 32'h83E7_0B13;
  localparam logic [31:0] M1 = 32'h95A4_F1E0;
  localparam int NVEC = 22;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] expRd;
    logic        expProt;
    logic        expUnl;
  } vec_t;

  // expRd/expProt sampled mid-cycle (before the edge), expUnl after the edge
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 8'h6C, 32'h0,        32'h0,        1'b0, 1'b0}, // R1 key reads zero
    '{1'b1, 8'h60, 32'hAAAA_AAAA, 32'h0,       1'b0, 1'b0}, // R4 dropped
    '{1'b0, 8'h60, 32'h0,        32'h0,        1'b0, 1'b0}, // R4 scratch unchanged
    '{1'b1, 8'h6C, M0,           32'h0,        1'b0, 1'b0}, // R6 key0
    '{1'b1, 8'h70, M1,           32'h0,        1'b0, 1'b1}, // R2 unlock
    '{1'b1, 8'h60, 32'h1111_1111, 32'h0,       1'b1, 1'b1}, // R5 R7 old value
    '{1'b0, 8'h60, 32'h0,        32'h1111_1111, 1'b0, 1'b1}, // R5 R8 read
    '{1'b1, 8'h64, 32'h2222_2222, 32'h0,       1'b1, 1'b1}, // R5
    '{1'b1, 8'h68, 32'h3333_3333, 32'h0,       1'b1, 1'b1}, // R5
    '{1'b1, 8'h10, 32'h5,        32'h0,        1'b1, 1'b1}, // R5 R9
    '{1'b0, 8'h64, 32'h0,        32'h2222_2222, 1'b0, 1'b1}, // R5
    '{1'b1, 8'h70, 32'h0,        M1,           1'b0, 1'b0}, // R3 R8 relock
    '{1'b1, 8'h60, 32'hDEAD_BEEF, 32'h1111_1111, 1'b0, 1'b0}, // R4 next cycle
    '{1'b0, 8'h60, 32'h0,        32'h1111_1111, 1'b0, 1'b0}, // R4 R7
    '{1'b1, 8'h70, M1,           32'h0,        1'b0, 1'b1}, // R2 key1 alone
    '{1'b1, 8'h6C, 32'h1234_5678, M0,          1'b0, 1'b0}, // R3 key0 bad
    '{1'b0, 8'h6C, 32'h0,        32'h1234_5678, 1'b0, 1'b0}, // R6 readback
    '{1'b1, 8'h6C, M0,           32'h1234_5678, 1'b0, 1'b1}, // R2 reverse order
    '{1'b1, 8'h6C, 32'h0,        M0,           1'b0, 1'b0}, // R3 zero
    '{1'b1, 8'h70, 32'h0,        M1,           1'b0, 1'b0}, // R3 zero
    '{1'b0, 8'h68, 32'h0,        32'h3333_3333, 1'b0, 1'b0}, // R7 locked read
    '{1'b1, 8'h10, 32'h7,        32'h0,        1'b0, 1'b0}  // R4 R9
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        protWrEn, unlocked;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  wp_unlock_gate dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWData(busWData),
    .busRData(busRData), .protWrEn(protWrEn), .unlocked(unlocked)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(unlocked == 1'b0, "R1 locked in reset", 32'(unlocked), 0);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      busWr = TBL[i].wr; busAddr = TBL[i].addr; busWData = TBL[i].data;
      #5;
      chk(busRData == TBL[i].expRd, $sformatf("vec%0d rdata R7 R9", i), busRData, TBL[i].expRd);
      chk(protWrEn == TBL[i].expProt, $sformatf("vec%0d protWrEn R4 R5 R8", i),
          32'(protWrEn), 32'(TBL[i].expProt));
      @(posedge clk); #1;
      chk(unlocked == TBL[i].expUnl, $sformatf("vec%0d unlocked R2 R3", i),
          32'(unlocked), 32'(TBL[i].expUnl));
    end

    // directed: unlock, fill scratch, then reset clears all (R1)
    @(negedge clk); busWr = 1'b1; busAddr = 8'h6C; busWData = M0;
    @(negedge clk); busAddr = 8'h70; busWData = M1;
    @(negedge clk); busAddr = 8'h64; busWData = 32'hCAFE_F00D;
    #5 chk(protWrEn == 1'b1, "R5 directed enable", 32'(protWrEn), 1);
    @(negedge clk); busWr = 1'b0;
    #5 chk(busRData == 32'hCAFE_F00D, "R5 directed store", busRData, 32'hCAFE_F00D);
    rstN = 1'b0;
    @(posedge clk); #1;
    chk(unlocked == 1'b0, "R1 reset relocks", 32'(unlocked), 0);
    busAddr = 8'h64; #1;
    chk(busRData == 32'h0, "R1 scratch cleared", busRData, 0);
    busAddr = 8'h6C; #1;
    chk(busRData == 32'h0, "R1 key0 cleared", busRData, 0);
    busAddr = 8'h70; #1;
    chk(busRData == 32'h0, "R1 key1 cleared", busRData, 0);
    @(negedge clk) rstN = 1'b1;
    busAddr = 8'h70; busWr = 1'b1; busWData = M1; // R8 key write never enables
    #5 chk(protWrEn == 1'b0, "R8 key write no enable", 32'(protWrEn), 0);
    @(negedge clk) busWr = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule